// File: doc/BRIEF.md
# Rate-1/3 Parallel Concatenated Convolutional Encoder

This block turns a block of K information bits into three coded streams: the information bits themselves, a parity stream from a recursive convolutional encoder that reads the bits in natural order, and a second parity stream from an identical encoder that reads the same bits in a scrambled order. The scrambled order comes from a quadratic permutation polynomial with coefficients f1 and f2. The block computes this order on the fly, using only modular additions. It does not read the order from a stored table.

A start pulse latches K, f1 and f2. The block then accepts exactly K bits over a valid/ready handshake into an on-chip buffer. After that it emits one coded triple per cycle for K cycles. It finishes with a termination tail that returns each encoder to the all-zero state: the first encoder terminates first, then the second. The output has no backpressure, so the consumer must take every triple in the cycle it is marked valid.

Top module: `turboEncoderTop`

## Requirements
- R1: After reset, `outValid` and `inReady` are 0 and the block is idle until `start` is pulsed.
- R2: A `start` pulse while idle latches `blkLen` (K, 1..MAX_K), `coefA` (f1) and `coefB` (f2), both below K. `inReady` then stays high until exactly K bits have been accepted. A bit is accepted on a rising edge with `inValid` and `inReady` both high. Cycles with `inValid` low are skipped.
- R3: After loading, the block emits K consecutive triples with `outTail` = 0. `sysBit` carries the accepted bits in arrival order.
- R4: `par1Bit` comes from an 8-state recursive encoder with state (s0,s1,s2), cleared at block start. Its feedback is a = u^s1^s2 (polynomial 1+D^2+D^3). Its parity is a^s0^s2 (polynomial 1+D+D^3). Its next state is (a,s0,s1).
- R5: `par2Bit` at output step i is the parity of an identical encoder, cleared at block start, whose input is the accepted bit at position (f1*i + f2*i*i) mod K.
- R6: The information triples are followed by 3 cycles with `outTail` = 1. In each of these cycles, `sysBit` is the first encoder's input u = s1^s2, `par1Bit` is its parity and `par2Bit` = 0.
- R7: Next come 3 cycles with `outTail` = 1. In each of these cycles, `sysBit` is the second encoder's u = s1^s2, `par2Bit` is its parity and `par1Bit` = 0. Both encoder states are zero afterwards.
- R8: A `start` pulse while a block is loading or being encoded is ignored. The block continues with its latched K, f1 and f2.
- R9: The smallest block (K = 1) and the largest block (K = MAX_K) produce the correct K+6 output cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new block (ignored when busy) |
| blkLen | input | $clog2(MAX_K+1) | Block length K |
| coefA | input | $clog2(MAX_K) | Linear permutation coefficient f1 |
| coefB | input | $clog2(MAX_K) | Quadratic permutation coefficient f2 |
| inBit | input | 1 | Information bit |
| inValid | input | 1 | `inBit` is valid |
| inReady | output | 1 | Block is accepting bits |
| sysBit | output | 1 | Systematic / tail input bit |
| par1Bit | output | 1 | Natural-order parity bit |
| par2Bit | output | 1 | Permuted-order parity bit |
| outValid | output | 1 | Output triple is valid |
| outTail | output | 1 | Output triple belongs to the termination tail |

## Verification
The bench targets K = 1 first. In that case the permutation increment reduces modulo 1, and an off-by-one in the length counter either hangs the block or emits a second information triple. It then runs K = MAX_K with large coefficients. There the modular additions wrap on almost every step, so a missing conditional subtraction corrupts `par2Bit` long before the tail. Input gaps and a stray `start` during loading are mixed in: a design that samples bits without `inValid`, or relatches K while busy, shifts every later triple. The tail ordering is also checked. Swapping the encoders, or feeding the data bit instead of the feedback during termination, shows up as wrong tail bits on the lanes.

// File: rtl/turboEncPkg.sv
package turboEncPkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_LOAD  = 3'd1,
    PH_ENC   = 3'd2,
    PH_TAIL1 = 3'd3,
    PH_TAIL2 = 3'd4
  } encPhase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic init;       // clear encoders, restart permutation
    logic wrEn;       // store inBit at index
    logic encStep;    // emit one information triple
    logic tail1Step;  // terminate first encoder one step
    logic tail2Step;  // terminate second encoder one step
    logic blockEnd;   // last tail step of the block
  } encStrobe_t;

  localparam int TAIL_LEN = 3;

endpackage

// File: rtl/rscEncoder.sv
module rscEncoder (
  input  logic       clk,
  input  logic       rstN,
  input  logic       clr,
  input  logic       step,
  input  logic       termMode,
  input  logic       dIn,
  output logic       uOut,
  output logic       zOut,
  output logic [2:0] stateOut
);
  logic [2:0] stateQ;   // stateQ[0] newest
  logic       fbBit;

  always_comb begin
    uOut  = termMode ? (stateQ[1] ^ stateQ[2]) : dIn;
    fbBit = uOut ^ stateQ[1] ^ stateQ[2];
    zOut  = fbBit ^ stateQ[0] ^ stateQ[2];
  end

  always_ff @(posedge clk) begin
    if (!rstN || clr) stateQ <= '0;
    else if (step)    stateQ <= {stateQ[1], stateQ[0], fbBit};
  end

  assign stateOut = stateQ;

  // R6
  term_drains_chk: assert property (@(posedge clk) disable iff (!rstN)
    (step && termMode && !clr) |=> (stateQ[0] == 1'b0));

endmodule

// File: rtl/qppAddrGen.sv
module qppAddrGen #(
  parameter int MAX_K = 256,
  localparam int AW = $clog2(MAX_K),
  localparam int KW = $clog2(MAX_K + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          init,
  input  logic          advance,
  input  logic [KW-1:0] lenIn,
  input  logic [AW-1:0] f1In,
  input  logic [AW-1:0] f2In,
  output logic [AW-1:0] addr
);
  logic [KW-1:0] kReg;
  logic [AW-1:0] piQ, gQ, stepQ;

  function automatic logic [AW-1:0] addMod(input logic [AW-1:0] a,
                                           input logic [AW-1:0] b,
                                           input logic [KW-1:0] k);
    logic [KW:0] s;
    s = (KW+1)'(a) + (KW+1)'(b);
    if (s >= (KW+1)'(k)) s = s - (KW+1)'(k);
    return s[AW-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      kReg  <= KW'(1);
      piQ   <= '0;
      gQ    <= '0;
      stepQ <= '0;
    end else if (init) begin
      kReg  <= lenIn;
      piQ   <= '0;
      gQ    <= addMod(f1In, f2In, lenIn);
      stepQ <= addMod(f2In, f2In, lenIn);
    end else if (advance) begin
      piQ <= addMod(piQ, gQ, kReg);
      gQ  <= addMod(gQ, stepQ, kReg);
    end
  end

  assign addr = piQ;

  // R5
  addr_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(advance) |-> (KW'(piQ) < kReg));

  // R5
  incr_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(init) |-> (KW'(gQ) < kReg && KW'(stepQ) < kReg));

endmodule

// File: rtl/encControl.sv
module encControl
  import turboEncPkg::*;
#(
  parameter int MAX_K = 256,
  localparam int AW = $clog2(MAX_K),
  localparam int KW = $clog2(MAX_K + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [KW-1:0] blkLen,
  input  logic          inValid,
  output logic          inReady,
  output logic [AW-1:0] idx,
  output encStrobe_t    strobe
);
  encPhase_t     phase;
  logic [KW-1:0] kReg;
  logic [AW-1:0] cnt;
  logic [1:0]    tailCnt;
  logic          lastIdx, accept, tailLast;

  assign lastIdx  = (KW'(cnt) + KW'(1)) == kReg;
  assign accept   = (phase == PH_LOAD) && inValid;
  assign tailLast = tailCnt == 2'(TAIL_LEN - 1);
  assign inReady  = (phase == PH_LOAD);
  assign idx      = cnt;

  always_comb begin
    strobe           = '0;
    strobe.init      = (phase == PH_IDLE) && start;
    strobe.wrEn      = accept;
    strobe.encStep   = (phase == PH_ENC);
    strobe.tail1Step = (phase == PH_TAIL1);
    strobe.tail2Step = (phase == PH_TAIL2);
    strobe.blockEnd  = (phase == PH_TAIL2) && tailLast;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      kReg    <= KW'(1);
      cnt     <= '0;
      tailCnt <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (start) begin
          phase <= PH_LOAD;
          kReg  <= blkLen;
          cnt   <= '0;
        end
        PH_LOAD: if (accept) begin
          if (lastIdx) begin
            phase <= PH_ENC;
            cnt   <= '0;
          end else cnt <= cnt + AW'(1);
        end
        PH_ENC: begin
          if (lastIdx) begin
            phase   <= PH_TAIL1;
            cnt     <= '0;
            tailCnt <= '0;
          end else cnt <= cnt + AW'(1);
        end
        PH_TAIL1: begin
          tailCnt <= tailLast ? 2'd0 : tailCnt + 2'd1;
          if (tailLast) phase <= PH_TAIL2;
        end
        PH_TAIL2: begin
          tailCnt <= tailLast ? 2'd0 : tailCnt + 2'd1;
          if (tailLast) phase <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R8
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase != PH_IDLE) |=> $stable(kReg));

  // R2
  load_only_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inReady) |-> $past(start));

endmodule

// File: rtl/encDatapath.sv
module encDatapath
  import turboEncPkg::*;
#(
  parameter int MAX_K = 256,
  localparam int AW = $clog2(MAX_K),
  localparam int KW = $clog2(MAX_K + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  encStrobe_t    strobe,
  input  logic [AW-1:0] idx,
  input  logic [KW-1:0] blkLen,
  input  logic [AW-1:0] coefA,
  input  logic [AW-1:0] coefB,
  input  logic          inBit,
  output logic          sysBit,
  output logic          par1Bit,
  output logic          par2Bit,
  output logic          outValid,
  output logic          outTail
);
  localparam int NENC = 2;

  logic [MAX_K-1:0] bitBuf;
  logic [AW-1:0]    permAddr;
  logic [NENC-1:0]  encIn, encStep, encTerm, encU, encZ;
  logic [2:0]       encState [NENC];

  always_ff @(posedge clk) begin
    if (!rstN)            bitBuf <= '0;
    else if (strobe.wrEn) bitBuf[idx] <= inBit;
  end

  qppAddrGen #(.MAX_K(MAX_K)) u_qpp (
    .clk(clk), .rstN(rstN), .init(strobe.init), .advance(strobe.encStep),
    .lenIn(blkLen), .f1In(coefA), .f2In(coefB), .addr(permAddr)
  );

  assign encIn   = {bitBuf[permAddr], bitBuf[idx]};
  assign encTerm = {strobe.tail2Step, strobe.tail1Step};
  assign encStep = {strobe.encStep | strobe.tail2Step,
                    strobe.encStep | strobe.tail1Step};

  for (genvar e = 0; e < NENC; e++) begin : gEnc
    rscEncoder u_rsc (
      .clk(clk), .rstN(rstN), .clr(strobe.init), .step(encStep[e]),
      .termMode(encTerm[e]), .dIn(encIn[e]), .uOut(encU[e]),
      .zOut(encZ[e]), .stateOut(encState[e])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sysBit <= 1'b0; par1Bit <= 1'b0; par2Bit <= 1'b0;
      outValid <= 1'b0; outTail <= 1'b0;
    end else begin
      outValid <= strobe.encStep | strobe.tail1Step | strobe.tail2Step;
      outTail  <= strobe.tail1Step | strobe.tail2Step;
      if (strobe.encStep) begin
        sysBit <= encU[0]; par1Bit <= encZ[0]; par2Bit <= encZ[1];
      end else if (strobe.tail1Step) begin
        sysBit <= encU[0]; par1Bit <= encZ[0]; par2Bit <= 1'b0;
      end else if (strobe.tail2Step) begin
        sysBit <= encU[1]; par1Bit <= 1'b0; par2Bit <= encZ[1];
      end
    end
  end

  // R7
  both_states_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.blockEnd |=> (encState[0] == 3'd0 && encState[1] == 3'd0));

  // R3
  single_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrEn, strobe.encStep, strobe.tail1Step, strobe.tail2Step}));

  // R1
  tail_has_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    outTail |-> outValid);

endmodule

// File: rtl/turboEncoderTop.sv
module turboEncoderTop
  import turboEncPkg::*;
#(
  parameter int MAX_K = 256,
  localparam int AW = $clog2(MAX_K),
  localparam int KW = $clog2(MAX_K + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic [KW-1:0] blkLen,
  input  logic [AW-1:0] coefA,
  input  logic [AW-1:0] coefB,
  input  logic          inBit,
  input  logic          inValid,
  output logic          inReady,
  output logic          sysBit,
  output logic          par1Bit,
  output logic          par2Bit,
  output logic          outValid,
  output logic          outTail
);
  encStrobe_t    strobe;
  logic [AW-1:0] idx;

  encControl #(.MAX_K(MAX_K)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .blkLen(blkLen),
    .inValid(inValid), .inReady(inReady), .idx(idx), .strobe(strobe)
  );

  encDatapath #(.MAX_K(MAX_K)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .idx(idx), .blkLen(blkLen),
    .coefA(coefA), .coefB(coefB), .inBit(inBit), .sysBit(sysBit),
    .par1Bit(par1Bit), .par2Bit(par2Bit), .outValid(outValid),
    .outTail(outTail)
  );

endmodule

// File: tb/turboEncoderTop_tb.sv
module turboEncoderTop_tb;
  localparam int MAX_K = 256;
  localparam int AW = $clog2(MAX_K);
  localparam int KW = $clog2(MAX_K + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [KW-1:0] blkLen = '0;
  logic [AW-1:0] coefA = '0, coefB = '0;
  logic inBit = 1'b0, inValid = 1'b0;
  logic inReady, sysBit, par1Bit, par2Bit, outValid, outTail;

  int nChecks = 0, nFails = 0;
  int cycles = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [4:0] expQ[$];   // {tail, sys, p1, p2, reqId-bit unused}
  string reqQ[$];

  always #10 clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  turboEncoderTop #(.MAX_K(MAX_K)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .blkLen(blkLen), .coefA(coefA),
    .coefB(coefB), .inBit(inBit), .inValid(inValid), .inReady(inReady),
    .sysBit(sysBit), .par1Bit(par1Bit), .par2Bit(par2Bit),
    .outValid(outValid), .outTail(outTail)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got tail/sys/p1/p2=%b expected %b", req, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (expQ.size() == 0) check("R3", {outTail, sysBit, par1Bit, par2Bit}, 4'bxxxx);
      else begin
        logic [4:0] e;
        string r;
        e = expQ.pop_front();
        r = reqQ.pop_front();
        check(r, {outTail, sysBit, par1Bit, par2Bit}, e[4:1]);
      end
    end
  end

  function automatic logic nextBit();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  task automatic modelStep(inout logic [2:0] s, input logic term, input logic d,
                           output logic u, output logic z);
    logic a;
    u = term ? (s[1] ^ s[2]) : d;
    a = u ^ s[1] ^ s[2];
    z = a ^ s[0] ^ s[2];
    s = {s[1], s[0], a};
  endtask

  task automatic runBlock(input int k, input int f1, input int f2,
                          input bit gaps, input bit strayStart, input string req);
    logic blk [MAX_K];
    logic [2:0] s1, s2;
    logic u1, z1, u2, z2;
    int i;
    for (int j = 0; j < k; j++) blk[j] = nextBit();
    s1 = '0; s2 = '0;
    for (int j = 0; j < k; j++) begin
      longint p;
      p = (longint'(f1) * j + longint'(f2) * j * j) % k;
      modelStep(s1, 1'b0, blk[j], u1, z1);
      modelStep(s2, 1'b0, blk[int'(p)], u2, z2);
      expQ.push_back({1'b0, blk[j], z1, z2, 1'b0});
      reqQ.push_back($sformatf("%s R3/R4/R5 step %0d", req, j));
    end
    for (int t = 0; t < 3; t++) begin
      modelStep(s1, 1'b1, 1'b0, u1, z1);
      expQ.push_back({1'b1, u1, z1, 1'b0, 1'b0});
      reqQ.push_back("R6 tail1");
    end
    for (int t = 0; t < 3; t++) begin
      modelStep(s2, 1'b1, 1'b0, u2, z2);
      expQ.push_back({1'b1, u2, 1'b0, z2, 1'b0});
      reqQ.push_back("R7 tail2");
    end
    check("R7 model state", {1'b0, s1 == 0, s2 == 0, 1'b0}, 4'b0110);
    @(negedge clk);
    start = 1'b1; blkLen = KW'(k); coefA = AW'(f1); coefB = AW'(f2);
    @(negedge clk);
    start = 1'b0;
    check("R2 ready", {3'b0, inReady}, 4'b0001);
    i = 0;
    while (i < k) begin
      @(negedge clk);
      if (strayStart && i == k / 2) begin
        start = 1'b1; blkLen = KW'(k == 1 ? 2 : k - 1); coefA = '0; coefB = '0;
      end else start = 1'b0;
      if (gaps && nextBit() && nextBit()) inValid = 1'b0;
      else if (inReady) begin
        inValid = 1'b1; inBit = blk[i]; i++;
      end else inValid = 1'b0;
    end
    @(negedge clk);
    inValid = 1'b0; start = 1'b0;
    check("R2 ready drops", {3'b0, inReady}, 4'b0000);
    while (expQ.size() != 0) @(negedge clk);
    @(negedge clk);
    check("R8/R9 no extra output", {3'b0, outValid}, 4'b0000);
  endtask

  initial begin
    bit timedOut = 0;
    fork
      begin
        repeat (3) @(negedge clk);
        check("R1 reset", {1'b0, outValid, inReady, 1'b0}, 4'b0000);
        rstN = 1'b1;
        @(negedge clk);
        check("R1 idle", {1'b0, outValid, inReady, 1'b0}, 4'b0000);
        runBlock(40, 3, 10, 0, 0, "basic");
        runBlock(1, 0, 0, 0, 0, "R9 K=1");
        runBlock(64, 7, 16, 1, 0, "R2 gaps");
        runBlock(104, 7, 26, 0, 1, "R8 stray start");
        runBlock(MAX_K, 255, 254, 1, 0, "R9 K=max");
        runBlock(24, 5, 0, 0, 0, "linear");
      end
      begin
        while (cycles < 150000) @(posedge clk);
        timedOut = 1;
      end
    join_any
    disable fork;
    if (timedOut) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule